// File: doc/BRIEF.md
# MDIO Management Master

This block is the management-bus master that a chip uses to reach external PHYs over a two-wire serial link: a clock output (MDC) and a bidirectional data line split here into an output, an output enable and an input. It builds complete frames in both the older 5-bit-register format (clause 22) and the extended format with separate device addressing (clause 45), shifts them out one bit per MDC period, and on reads turns the line around and collects 16 bits from the PHY.

Software sees four 32-bit registers through a simple write-strobe bus with combinational read-back. A configuration register selects the frame format, enables the preamble and sets the MDC divider. Writing the command register starts exactly one frame; completion is seen through a pending flag in the write-data register (writes and address frames) or in the read-data register (reads), and a read result carries a valid flag. A clause 45 register access is made by software as two frames: an address frame that carries the target register number from the write-data register, then a write or read frame to the same PHY and device.

Top module: `mdio_master`

## Requirements
- R1: Register map by `reg_addr`: 0 = configuration (bit 0 format select, 0 = clause 22, 1 = clause 45; bit 1 preamble enable; bits 8 and up hold the divider value `div`), 1 = command (bits 1:0 op code, bits 12:8 PHY address, bits 20:16 register or device address), 2 = write data (bits 15:0 value, bit 31 pending), 3 = read data (bits 15:0 value, bit 30 valid, bit 31 pending). After reset the configuration reads format 0, preamble 1, divider `DIV_RST`; every other register reads 0, MDC is low and the line is released.
- R2: A write or address frame sets the write-data pending bit and a read frame sets the read-data pending bit and clears valid; the flag drops when the frame's last bit ends, and pending and valid are never both 1.
- R3: MDC is low whenever no frame runs; during a frame each half period lasts `div`+1 system clocks starting with a low half, so a frame of N bits keeps its pending flag set for exactly 2*(`div`+1)*N clocks.
- R4: The master changes its line outputs only when MDC falls (or at the launch of a frame) and samples `mdio_i` on the system clock edge where MDC rises.
- R5: Clause 22 frame, MSB first: start 01, opcode 01 for a write or 10 for a read (op code bit 0 = 1 selects read, bit 1 ignored), 5-bit PHY address, 5-bit register address, turnaround, 16 data bits.
- R6: Clause 45 frame: start 00, opcode equal to the op code (0 address, 1 write, 2 read with post-increment, 3 read), PHY address, 5-bit device address in the register field; address and write frames send the 16-bit write-data value in the data field.
- R7: With preamble enabled, 32 ones precede the frame (N = 64); with it disabled the frame starts directly with the start code (N = 32).
- R8: On a read the master drives the first 14 frame bits and releases the line for the remaining 18; the 16 bits sampled after turnaround land MSB first in read-data bits 15:0 with valid set. On writes it drives all bits, turnaround 10.
- R9: If the PHY does not pull the second turnaround bit low, the read completes with valid = 0.
- R10: A command written while a frame is pending is ignored: the running frame's bits, length and the command register read-back are unchanged and no further frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for write and read-back |
| reg_wdata | input | 32 | Register write value |
| reg_rdata | output | 32 | Read-back of the selected register |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | Serial data driven by the master |
| mdio_oe | output | 1 | High while the master drives the data line |
| mdio_i | input | 1 | Serial data seen on the line |

## Verification
The hardest situation to reach from the ports is a command arriving while a frame is in flight, since the pending flag hides it unless software ignores it; the bench injects a second command from inside its completion poll loop a few clocks after launch and then checks bit count, captured bits, cycle count and command read-back. A PHY model reacts to MDC edges, capturing driven bits on each rise and presenting turnaround and data on each fall, and can hold the second turnaround bit high to provoke a failed read. Every format, op code, preamble setting and three divider values are swept, with the frame image and the exact frame duration computed arithmetically.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PHY_W  = 5;
    localparam int REG_W  = 5;
    localparam int DATA_W = 16;
    localparam int POS_W  = 6;

    // register select codes
    localparam logic [1:0] SEL_CFG  = 2'd0;
    localparam logic [1:0] SEL_CMD  = 2'd1;
    localparam logic [1:0] SEL_WDAT = 2'd2;
    localparam logic [1:0] SEL_RDAT = 2'd3;

    // bit positions within the 32-bit frame (0 = start code MSB)
    localparam logic [4:0] HDR_LAST   = 5'd13;
    localparam logic [4:0] TA_LOW_IDX = 5'd15;
    localparam logic [4:0] DATA_FIRST = 5'd16;

    localparam logic [POS_W-1:0] POS_FRAME0 = 6'd32;
    localparam logic [POS_W-1:0] POS_LAST   = 6'd63;

    typedef struct packed {
        logic [1:0]       op;
        logic [PHY_W-1:0] phy;
        logic [REG_W-1:0] regad;
    } cmd_t;

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             mdc,
    output logic             rise_p,
    output logic             fall_p
);
    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic             mdc_d, mdc_q;
    logic             turn;

    always_comb begin
        turn  = run && (cnt_q == half);
        cnt_d = cnt_q;
        mdc_d = mdc_q;
        if (!run) begin
            cnt_d = '0;
            mdc_d = 1'b0;
        end else if (turn) begin
            cnt_d = '0;
            mdc_d = !mdc_q;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            mdc_q <= mdc_d;
        end
    end

    assign mdc    = mdc_q;
    assign rise_p = turn && !mdc_q;
    assign fall_p = turn && mdc_q;

endmodule

// File: rtl/mdio_frame_fmt.sv
module mdio_frame_fmt
    import mdio_pkg::*;
(
    input  logic              ext_mode,
    input  cmd_t              cmd,
    input  logic [DATA_W-1:0] wdat,
    output logic [31:0]       frame,
    output logic              is_read
);
    logic [1:0] start_code;
    logic [1:0] op_bits;

    always_comb begin
        if (ext_mode) begin
            start_code = 2'b00;
            op_bits    = cmd.op;
            is_read    = cmd.op[1];
        end else begin
            start_code = 2'b01;
            op_bits    = cmd.op[0] ? 2'b10 : 2'b01;
            is_read    = cmd.op[0];
        end
        frame = {start_code, op_bits, cmd.phy, cmd.regad, 2'b10, wdat};
    end

endmodule

// File: rtl/mdio_bit_sel.sv
module mdio_bit_sel
    import mdio_pkg::*;
(
    input  logic [POS_W-1:0] pos,
    input  logic [31:0]      frame,
    input  logic             is_read,
    output logic             bit_o,
    output logic             drive_o
);
    logic       in_pre;
    logic [4:0] idx;

    always_comb begin
        in_pre  = !pos[POS_W-1];
        idx     = pos[4:0];
        bit_o   = in_pre ? 1'b1 : frame[5'd31 - idx];
        drive_o = in_pre || !is_read || (idx <= HDR_LAST);
    end

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int DIV_RST = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    localparam int DIV_LSB = 8;

    typedef struct packed {
        logic                ext_mode;
        logic                pre_en;
        logic [DIV_W-1:0]    div;
        logic [DATA_W-1:0]   wdat;
        cmd_t                cmd;
        logic                busy;
        logic                rd;
        logic [DIV_W-1:0]    div_run;
        logic [31:0]         frame;
        logic [POS_W-1:0]    pos;
        logic                wr_pend;
        logic                rd_pend;
        logic                rd_valid;
        logic                ta_ok;
        logic [DATA_W-1:0]   rd_sh;
        logic [DATA_W-1:0]   rd_dat;
    } state_t;

    state_t st_d, st_q;

    cmd_t        new_cmd;
    logic [31:0] fmt_frame;
    logic        fmt_read;
    logic        rise_p, fall_p;
    logic        line_bit, line_drive;
    logic        busy_w, wr_pend_w, rd_pend_w, rd_valid_w;
    logic [31:0] frame_w;
    logic        unused_wdata;
    logic [4:0]  fidx;

    assign new_cmd = '{op: reg_wdata[1:0], phy: reg_wdata[12:8], regad: reg_wdata[20:16]};
    assign unused_wdata = ^reg_wdata[31:21];

    mdio_frame_fmt fmt_i (
        .ext_mode (st_q.ext_mode),
        .cmd      (new_cmd),
        .wdat     (st_q.wdat),
        .frame    (fmt_frame),
        .is_read  (fmt_read)
    );

    mdio_mdc_gen #(.DIV_W(DIV_W)) clk_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (st_q.busy),
        .half   (st_q.div_run),
        .mdc    (mdc),
        .rise_p (rise_p),
        .fall_p (fall_p)
    );

    mdio_bit_sel sel_i (
        .pos     (st_q.pos),
        .frame   (frame_w),
        .is_read (st_q.rd),
        .bit_o   (line_bit),
        .drive_o (line_drive)
    );

    assign busy_w     = st_q.busy;
    assign wr_pend_w  = st_q.wr_pend;
    assign rd_pend_w  = st_q.rd_pend;
    assign rd_valid_w = st_q.rd_valid;
    assign frame_w    = st_q.frame;
    assign fidx       = st_q.pos[4:0];

    assign mdio_o  = busy_w ? line_bit : 1'b1;
    assign mdio_oe = busy_w && line_drive;

    always_comb begin
        st_d = st_q;

        if (reg_we) begin
            case (reg_addr)
                SEL_CFG: begin
                    st_d.ext_mode = reg_wdata[0];
                    st_d.pre_en   = reg_wdata[1];
                    st_d.div      = reg_wdata[DIV_LSB +: DIV_W];
                end
                SEL_WDAT: st_d.wdat = reg_wdata[DATA_W-1:0];
                SEL_CMD: begin
                    if (!st_q.busy) begin
                        st_d.cmd     = new_cmd;
                        st_d.busy    = 1'b1;
                        st_d.rd      = fmt_read;
                        st_d.frame   = fmt_frame;
                        st_d.div_run = st_q.div;
                        st_d.pos     = st_q.pre_en ? '0 : POS_FRAME0;
                        st_d.ta_ok   = 1'b1;
                        if (fmt_read) begin
                            st_d.rd_pend  = 1'b1;
                            st_d.rd_valid = 1'b0;
                        end else begin
                            st_d.wr_pend  = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end

        if (st_q.busy) begin
            if (rise_p && st_q.rd && st_q.pos[POS_W-1]) begin
                if (fidx == TA_LOW_IDX) begin
                    st_d.ta_ok = !mdio_i;
                end
                if (fidx >= DATA_FIRST) begin
                    st_d.rd_sh = {st_q.rd_sh[DATA_W-2:0], mdio_i};
                end
            end
            if (fall_p) begin
                if (st_q.pos == POS_LAST) begin
                    st_d.busy    = 1'b0;
                    st_d.wr_pend = 1'b0;
                    if (st_q.rd) begin
                        st_d.rd_pend  = 1'b0;
                        st_d.rd_valid = st_q.ta_ok;
                        st_d.rd_dat   = st_q.rd_sh;
                    end
                end else begin
                    st_d.pos = st_q.pos + 6'd1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.pre_en <= 1'b1;
            st_q.div    <= DIV_W'(DIV_RST);
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            SEL_CFG: begin
                reg_rdata[0]                  = st_q.ext_mode;
                reg_rdata[1]                  = st_q.pre_en;
                reg_rdata[DIV_LSB +: DIV_W]   = st_q.div;
            end
            SEL_CMD: begin
                reg_rdata[1:0]   = st_q.cmd.op;
                reg_rdata[12:8]  = st_q.cmd.phy;
                reg_rdata[20:16] = st_q.cmd.regad;
            end
            SEL_WDAT: begin
                reg_rdata[31]          = wr_pend_w;
                reg_rdata[DATA_W-1:0]  = st_q.wdat;
            end
            default: begin
                reg_rdata[31]          = rd_pend_w;
                reg_rdata[30]          = rd_valid_w;
                reg_rdata[DATA_W-1:0]  = st_q.rd_dat;
            end
        endcase
    end

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        busy,
    input logic        wr_pend,
    input logic        rd_pend,
    input logic        rd_valid,
    input logic [31:0] frame
);
    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    // R3
    mdc_rise_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> busy);

    // R4
    line_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({mdio_o, mdio_oe}) |-> ($fell(mdc) || $rose(busy)));

    // R2
    one_flag_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $onehot({wr_pend, rd_pend}));

    // R2
    flags_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!wr_pend && !rd_pend));

    // R2
    pend_valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_pend && rd_valid));

    // R10
    frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(frame));

endmodule

bind mdio_master mdio_master_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .busy     (busy_w),
    .wr_pend  (wr_pend_w),
    .rd_pend  (rd_pend_w),
    .rd_valid (rd_valid_w),
    .frame    (frame_w)
);

// File: tb/mdio_master_tb_top.sv
module mdio_master_tb_top;

    localparam int DIV_RST = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i;

    int checks = 0;
    int errors = 0;

    // PHY model state
    int          nrise;
    int          pre_len;
    logic [63:0] cap_v, cap_oe;
    logic        ta_bad;
    logic [15:0] resp;

    always #5 clk = ~clk;

    mdio_master #(.DIV_W(8), .DIV_RST(DIV_RST)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    always @(posedge mdc) begin
        cap_v  = {cap_v[62:0], mdio_o};
        cap_oe = {cap_oe[62:0], mdio_oe};
        nrise  = nrise + 1;
    end

    always @(negedge mdc) begin
        int f;
        f = nrise - pre_len;
        if (f == 15)                mdio_i = ta_bad;
        else if (f >= 16 && f <= 31) mdio_i = resp[31 - f];
        else                        mdio_i = 1'b1;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic run_frame(input bit ext, input bit pre, input int div,
                             input logic [1:0] op, input logic [4:0] phy,
                             input logic [4:0] rg, input logic [15:0] wd,
                             input logic [15:0] rs, input bit tab, input bit poke);
        logic [31:0] fr, rv;
        logic [63:0] exp_v, exp_oe;
        logic [1:0]  stc, opb, pa;
        bit          is_rd, seen;
        int          n, cyc, rise_end;
        string       tag;

        tag = ext ? "R6" : "R5";
        wr_reg(2'd0, (32'(div) << 8) | (32'(pre) << 1) | 32'(ext));
        wr_reg(2'd2, {16'h0, wd});
        nrise = 0; cap_v = '0; cap_oe = '0;
        pre_len = pre ? 32 : 0;
        resp = rs; ta_bad = tab;

        is_rd = ext ? op[1] : op[0];
        stc   = ext ? 2'b00 : 2'b01;
        opb   = ext ? op : (op[0] ? 2'b10 : 2'b01);
        fr    = {stc, opb, phy, rg, 2'b10, wd};
        n     = pre_len + 32;
        exp_v  = pre ? {32'hFFFF_FFFF, fr} : {32'h0, fr};
        exp_oe = {(pre ? 32'hFFFF_FFFF : 32'h0), (is_rd ? 32'hFFFC_0000 : 32'hFFFF_FFFF)};
        pa = is_rd ? 2'd3 : 2'd2;

        @(negedge clk);
        reg_we = 1'b1; reg_addr = 2'd1;
        reg_wdata = {11'h0, rg, 3'h0, phy, 6'h0, op};
        cyc = 0;
        do begin
            @(negedge clk);
            reg_we = 1'b0; reg_addr = pa;
            if (poke && cyc == 5) begin
                reg_we = 1'b1; reg_addr = 2'd1;
                reg_wdata = {11'h0, ~rg, 3'h0, ~phy, 6'h0, ~op};
                #1; seen = 1'b1;
            end else begin
                #1; seen = reg_rdata[31];
                if (cyc == 0 && is_rd)
                    chk("R2 read pending set valid clear", 64'(reg_rdata[31:30]), 64'h2);
                if (cyc == 0 && !is_rd)
                    chk("R2 write pending set", 64'(reg_rdata[31]), 64'h1);
            end
            if (seen) cyc++;
        end while (seen);

        chk("R3 frame duration", 64'(cyc), 64'(2 * (div + 1) * n));
        chk("R7 bit count", 64'(nrise), 64'(n));
        chk({tag, " R8 drive pattern"}, cap_oe, exp_oe);
        chk({tag, " R7 driven bits"}, cap_v & exp_oe, exp_v & exp_oe);
        if (is_rd) begin
            rd_reg(2'd3, rv);
            if (tab) chk("R9 bad turnaround", 64'(rv), {32'h0, 16'h0, rs});
            else     chk("R8 R4 read result", 64'(rv), {32'h0, 16'h4000, rs});
        end
        if (poke) begin
            rise_end = nrise;
            repeat (40) @(negedge clk);
            chk("R10 no second frame", 64'(nrise), 64'(rise_end));
            rd_reg(2'd1, rv);
            chk("R10 command kept", 64'(rv), {32'h0, 11'h0, rg, 3'h0, phy, 6'h0, op});
            rd_reg(2'd2, rv);
            chk("R10 idle after ignored command", 64'(rv[31]), 64'h0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
        mdio_i = 1'b1; nrise = 0; pre_len = 0; cap_v = '0; cap_oe = '0;
        ta_bad = 1'b0; resp = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_reg(2'd0, rv); chk("R1 config reset", 64'(rv), 64'(32'(DIV_RST) << 8 | 32'h2));
        rd_reg(2'd1, rv); chk("R1 command reset", 64'(rv), 64'h0);
        rd_reg(2'd2, rv); chk("R1 write data reset", 64'(rv), 64'h0);
        rd_reg(2'd3, rv); chk("R1 read data reset", 64'(rv), 64'h0);
        chk("R1 R3 line idle", {62'h0, mdc, mdio_oe}, 64'h0);

        wr_reg(2'd0, 32'h0000_0301);
        rd_reg(2'd0, rv); chk("R1 config readback", 64'(rv), 64'h301);

        // sweep of divider, preamble, format and op code
        for (int d = 0; d < 3; d++) begin
            for (int p = 0; p < 2; p++) begin
                for (int e = 0; e < 2; e++) begin
                    for (int o = 0; o < 4; o++) begin
                        run_frame(e[0], p[0], d, o[1:0],
                                  5'((d * 7 + o * 3 + p + e * 11) % 32),
                                  5'((d * 5 + o * 9 + e * 2 + 17) % 32),
                                  16'hA5C3 ^ 16'(d << 4) ^ 16'(o << 9) ^ 16'(e),
                                  16'h1234 + 16'(d * 257) + 16'(o * 4369) + 16'(p * 4096),
                                  1'b0, 1'b0);
                    end
                end
            end
        end

        // extremes of field values
        run_frame(1'b0, 1'b1, 0, 2'd0, 5'd31, 5'd31, 16'hFFFF, 16'h0000, 1'b0, 1'b0);
        run_frame(1'b0, 1'b0, 1, 2'd1, 5'd0,  5'd0,  16'h0000, 16'hFFFF, 1'b0, 1'b0);
        run_frame(1'b1, 1'b1, 0, 2'd0, 5'd31, 5'd0,  16'h8001, 16'h0000, 1'b0, 1'b0);
        run_frame(1'b1, 1'b0, 0, 2'd3, 5'd0,  5'd31, 16'h0000, 16'h8001, 1'b0, 1'b0);

        // R9 turnaround not driven low
        run_frame(1'b0, 1'b1, 0, 2'd1, 5'd3, 5'd2, 16'h0, 16'h5A5A, 1'b1, 1'b0);
        run_frame(1'b1, 1'b0, 1, 2'd2, 5'd9, 5'd1, 16'h0, 16'hC003, 1'b1, 1'b0);
        // a good read afterwards restores valid
        run_frame(1'b1, 1'b0, 0, 2'd3, 5'd9, 5'd1, 16'h0, 16'h3CC3, 1'b0, 1'b0);

        // R10 command while pending
        run_frame(1'b0, 1'b0, 0, 2'd0, 5'd6, 5'd12, 16'h1357, 16'h0, 1'b0, 1'b1);
        run_frame(1'b1, 1'b1, 1, 2'd3, 5'd21, 5'd4, 16'h0, 16'hBEEF, 1'b0, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule